// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block sits beside the command bus of a four-bank double-data-rate SDRAM controller and judges every command, one decoded command per clock. It keeps a small state machine and a countdown for each bank, and a shared record of the most recent auto-precharge access. From these it flags commands that hit a bank in the wrong state, arrive too early after an auto-precharge access on another bank, or break the all-banks-idle, burst-terminate or read-then-write rules.

Auto precharge is modelled as two back-to-back phases. In the access phase the bank refuses every command. Commands to other banks must keep minimum gaps that depend on whether the access was a read or a write. In the precharge phase the bank closes itself and becomes Idle after tRP. CAS latency, burst length, tRP, tRCD, tWR and tWTR are static inputs given in clock cycles.

Top module: `ddr_cmd_checker`

## Requirements
- R1: Command encoding on `cmd_i` is 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST TERMINATE, 6 AUTO REFRESH, 7 LOAD MODE. Bank b's state is shown on `bank_state_o[3b+2:3b]` with the codes 0 Idle, 1 opening, 2 Row Active, 3 reading, 4 writing, 5 read-auto-precharge access, 6 write-auto-precharge access, 7 precharging. ACTIVE is legal only on an Idle bank. The bank shows opening and becomes Row Active tRCD cycles after the ACTIVE. A READ issued before that gives violation code 1.
- R2: PRECHARGE is legal on an Idle or Row Active bank. A Row Active bank shows precharging and is Idle tRP cycles after the command. An ACTIVE issued before that gives code 1.
- R3: READ is legal on a Row Active or reading bank, and WRITE on a Row Active or writing bank. Without auto precharge, the bank shows reading or writing for BL/2 cycles and then returns to Row Active.
- R4: After READ with auto precharge, the bank shows its access state for BL/2 cycles, then precharging, and is Idle BL/2 + tRP cycles after the READ. Any command to it before then gives code 1.
- R5: After WRITE with auto precharge, precharging starts 1 + BL/2 + tWR cycles after the WRITE and the bank is Idle tRP cycles later. A command to the bank during the access phase gives code 1.
- R6: After a WRITE with auto precharge, a command to another bank must wait at least these numbers of cycles, or it gets code 2: READ 1 + BL/2 + tWTR, WRITE BL/2, PRECHARGE 1, ACTIVE 1.
- R7: After a READ with auto precharge, a command to another bank must wait at least these numbers of cycles, or it gets code 2: READ BL/2, WRITE CL + BL/2, PRECHARGE 1, ACTIVE 1.
- R8: AUTO REFRESH and LOAD MODE are legal only while every bank is Idle. Otherwise they give code 3.
- R9: BURST TERMINATE is legal only on a bank that is reading, and returns that bank to Row Active. Any other use gives code 4.
- R10: A WRITE while any bank is reading gives code 5. When several rules fail, code 1 wins over code 5, and code 5 wins over code 2.
- R11: `viol_o` and `viol_code_o` report the command captured at the previous clock edge. Code 0 and `viol_o` low mean legal. A flagged command changes no bank state.
- R12: `cfg_err_o` rises one cycle after an illegal setting and stays high until reset. A setting is illegal when BL is not 2, 4 or 8, when CL is not 2 or 3, or when tRP or tRCD is zero.
- R13: Synchronous active-high reset makes every bank Idle and clears the violation outputs and `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command of this cycle |
| bank_i | input | BA_W (2) | Target bank |
| ap_i | input | 1 | Auto-precharge flag for READ/WRITE |
| cl_i | input | 2 | CAS latency in cycles (2.5 given as 3) |
| bl_i | input | 4 | Burst length |
| trp_i | input | CNT_W | tRP in cycles |
| trcd_i | input | CNT_W | tRCD in cycles |
| twr_i | input | CNT_W | tWR in cycles |
| twtr_i | input | CNT_W | tWTR in cycles |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Reason for the violation |
| bank_state_o | output | 3*NBANK | Current state of each bank |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
A bank countdown or state that drifts by even one cycle appears on `bank_state_o` in the cycle after the command that loaded it. The bench therefore probes each transition at its exact boundary: one cycle before it and at it. A wrong auto-precharge age or a wrong gap formula shows up as a missing or spurious code 2 on the very next cycle. The stimulus places commands one cycle short of each gap and then exactly on it. A bank that wrongly absorbs a rejected command shows the wrong state right away, and later produces a wrong code on a follow-up command.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

   typedef enum logic [2:0] {
      C_NOP = 3'd0, C_ACT = 3'd1, C_RD  = 3'd2, C_WR  = 3'd3,
      C_PRE = 3'd4, C_BST = 3'd5, C_REF = 3'd6, C_LMR = 3'd7
   } cmd_e;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0, S_OPENING = 3'd1, S_OPEN = 3'd2, S_RDING = 3'd3,
      S_WRING = 3'd4, S_RDAP = 3'd5, S_WRAP = 3'd6, S_CLOSING = 3'd7
   } bank_st_e;

   typedef enum logic [2:0] {
      V_NONE = 3'd0, V_STATE = 3'd1, V_GAP = 3'd2, V_ALLIDLE = 3'd3,
      V_BST = 3'd4, V_RDWR = 3'd5
   } viol_e;

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
   import ddr_chk_pkg::*;
#(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          apply_i,
   input  cmd_e          cmd_i,
   input  logic          ap_i,
   input  logic [CW-1:0] ld_rcd_i,
   input  logic [CW-1:0] ld_rp_i,
   input  logic [CW-1:0] ld_burst_i,
   input  logic [CW-1:0] ld_wrap_i,
   output bank_st_e      eff_o
);

   bank_st_e      state;
   logic [CW-1:0] cnt;
   logic          cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_comb begin
      case (state)
         S_OPENING:        eff_o = cnt_zero ? S_OPEN : S_OPENING;
         S_RDING, S_WRING: eff_o = cnt_zero ? S_OPEN : state;
         S_CLOSING:        eff_o = cnt_zero ? S_IDLE : S_CLOSING;
         default:          eff_o = state;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= S_IDLE;
         cnt   <= '0;
      end else if (apply_i) begin
         case (cmd_i)
            C_ACT: begin
               state <= S_OPENING;
               cnt   <= ld_rcd_i;
            end
            C_RD: begin
               state <= ap_i ? S_RDAP : S_RDING;
               cnt   <= ld_burst_i;
            end
            C_WR: begin
               state <= ap_i ? S_WRAP : S_WRING;
               cnt   <= ap_i ? ld_wrap_i : ld_burst_i;
            end
            C_PRE: begin
               state <= (eff_o == S_IDLE) ? S_IDLE : S_CLOSING;
               cnt   <= (eff_o == S_IDLE) ? '0 : ld_rp_i;
            end
            C_BST: begin
               state <= S_OPEN;
               cnt   <= '0;
            end
            default: begin
               state <= eff_o;
               cnt   <= cnt_zero ? '0 : cnt - CW'(1);
            end
         endcase
      end else if ((state == S_RDAP || state == S_WRAP) && cnt_zero) begin
         state <= S_CLOSING;
         cnt   <= ld_rp_i;
      end else begin
         state <= eff_o;
         cnt   <= cnt_zero ? '0 : cnt - CW'(1);
      end
   end

   // R1: the top only opens a bank that this tracker reports Idle
   assert_act_from_idle_R1: assert property (@(posedge clk) disable iff (rst)
      (apply_i && cmd_i == C_ACT) |-> (eff_o == S_IDLE));

   // R3: reads are only accepted on an open or reading bank
   assert_rd_from_open_R3: assert property (@(posedge clk) disable iff (rst)
      (apply_i && cmd_i == C_RD) |-> (eff_o inside {S_OPEN, S_RDING}));

   // R4: an expired auto-precharge access moves into the precharge phase
   assert_ap_closes_R4: assert property (@(posedge clk) disable iff (rst)
      ((state == S_RDAP || state == S_WRAP) && cnt_zero) |=> (state == S_CLOSING));

endmodule

// File: rtl/ddr_ap_gap.sv
module ddr_ap_gap
   import ddr_chk_pkg::*;
#(
   parameter int BA_W = 2,
   parameter int AW   = 7
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            arm_i,
   input  logic            arm_wr_i,
   input  logic [BA_W-1:0] arm_bank_i,
   input  cmd_e            cmd_i,
   input  logic [BA_W-1:0] bank_i,
   input  logic [AW-1:0]   blh_i,
   input  logic [AW-1:0]   cl_i,
   input  logic [AW-1:0]   twtr_i,
   output logic            ok_o
);

   logic            valid;
   logic            was_wr;
   logic [BA_W-1:0] abank;
   logic [AW-1:0]   age;
   logic [AW-1:0]   need;

   always_comb begin
      need = '0;
      if (valid && bank_i != abank) begin
         case (cmd_i)
            C_RD:         need = was_wr ? (AW'(1) + blh_i + twtr_i) : blh_i;
            C_WR:         need = was_wr ? blh_i : (cl_i + blh_i);
            C_PRE, C_ACT: need = AW'(1);
            default:      need = '0;
         endcase
      end
   end

   assign ok_o = (age >= need);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid  <= 1'b0;
         was_wr <= 1'b0;
         abank  <= '0;
         age    <= '0;
      end else if (arm_i) begin
         valid  <= 1'b1;
         was_wr <= arm_wr_i;
         abank  <= arm_bank_i;
         age    <= AW'(1);
      end else if (age != '1) begin
         age <= age + AW'(1);
      end
   end

   // R6: a read on another bank right after a write-AP is never cleared
   assert_wrap_rd_gap_R6: assert property (@(posedge clk) disable iff (rst)
      (arm_i && arm_wr_i) |=> !(cmd_i == C_RD && bank_i != $past(arm_bank_i) && ok_o));

   // R7: a write on another bank right after a read-AP is never cleared
   assert_rdap_wr_gap_R7: assert property (@(posedge clk) disable iff (rst)
      (arm_i && !arm_wr_i) |=> !(cmd_i == C_WR && bank_i != $past(arm_bank_i) && ok_o));

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
   import ddr_chk_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int CNT_W = 4,
   localparam int BA_W = $clog2(NBANK)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2:0]           cmd_i,
   input  logic [BA_W-1:0]      bank_i,
   input  logic                 ap_i,
   input  logic [1:0]           cl_i,
   input  logic [3:0]           bl_i,
   input  logic [CNT_W-1:0]     trp_i,
   input  logic [CNT_W-1:0]     trcd_i,
   input  logic [CNT_W-1:0]     twr_i,
   input  logic [CNT_W-1:0]     twtr_i,
   output logic                 viol_o,
   output logic [2:0]           viol_code_o,
   output logic [3*NBANK-1:0]   bank_state_o,
   output logic                 cfg_err_o
);

   localparam int BCW = CNT_W + 2;
   localparam int AW  = CNT_W + 3;

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("CNT_W must be at least 2");
   end

   cmd_e            cmd;
   bank_st_e        eff [NBANK];
   bank_st_e        sel;
   logic [NBANK-1:0] apply;
   viol_e           code;
   logic            any_rd, all_idle, gap_ok, arm, cfg_ok;
   logic [BCW-1:0]  ld_rcd, ld_rp, ld_burst, ld_wrap, blh_b;
   logic [AW-1:0]   blh_a;

   assign cmd    = cmd_e'(cmd_i);
   assign blh_b  = BCW'(bl_i[3:1]);
   assign blh_a  = AW'(bl_i[3:1]);
   assign ld_rcd   = (trcd_i == '0) ? '0 : BCW'(trcd_i) - BCW'(1);
   assign ld_rp    = (trp_i == '0) ? '0 : BCW'(trp_i) - BCW'(1);
   assign ld_burst = (blh_b == '0) ? '0 : blh_b - BCW'(1);
   assign ld_wrap  = blh_b + BCW'(twr_i);

   assign cfg_ok = (bl_i == 4'd2 || bl_i == 4'd4 || bl_i == 4'd8) &&
                   (cl_i == 2'd2 || cl_i == 2'd3) &&
                   (trp_i != '0) && (trcd_i != '0);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign apply[b] = (code == V_NONE) && (bank_i == BA_W'(b)) &&
                        (cmd inside {C_ACT, C_RD, C_WR, C_PRE, C_BST});
      ddr_bank_track #(.CW(BCW)) u_track (
         .clk        (clk),
         .rst        (rst),
         .apply_i    (apply[b]),
         .cmd_i      (cmd),
         .ap_i       (ap_i),
         .ld_rcd_i   (ld_rcd),
         .ld_rp_i    (ld_rp),
         .ld_burst_i (ld_burst),
         .ld_wrap_i  (ld_wrap),
         .eff_o      (eff[b])
      );
      assign bank_state_o[3*b +: 3] = eff[b];
   end

   assign arm = (code == V_NONE) && (cmd == C_RD || cmd == C_WR) && ap_i;

   ddr_ap_gap #(.BA_W(BA_W), .AW(AW)) u_gap (
      .clk        (clk),
      .rst        (rst),
      .arm_i      (arm),
      .arm_wr_i   (cmd == C_WR),
      .arm_bank_i (bank_i),
      .cmd_i      (cmd),
      .bank_i     (bank_i),
      .blh_i      (blh_a),
      .cl_i       (AW'(cl_i)),
      .twtr_i     (AW'(twtr_i)),
      .ok_o       (gap_ok)
   );

   always_comb begin
      any_rd   = 1'b0;
      all_idle = 1'b1;
      for (int b = 0; b < NBANK; b++) begin
         if (eff[b] == S_RDING) any_rd = 1'b1;
         if (eff[b] != S_IDLE)  all_idle = 1'b0;
      end
   end

   always_comb begin
      sel  = eff[bank_i];
      code = V_NONE;
      case (cmd)
         C_ACT: if (sel != S_IDLE) code = V_STATE;
                else if (!gap_ok) code = V_GAP;
         C_RD:  if (!(sel inside {S_OPEN, S_RDING})) code = V_STATE;
                else if (!gap_ok) code = V_GAP;
         C_WR:  if (!(sel inside {S_OPEN, S_WRING})) code = V_STATE;
                else if (any_rd) code = V_RDWR;
                else if (!gap_ok) code = V_GAP;
         C_PRE: if (!(sel inside {S_IDLE, S_OPEN})) code = V_STATE;
                else if (!gap_ok) code = V_GAP;
         C_BST: if (sel != S_RDING) code = V_BST;
         C_REF, C_LMR: if (!all_idle) code = V_ALLIDLE;
         default: code = V_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         viol_o      <= 1'b0;
         viol_code_o <= 3'd0;
         cfg_err_o   <= 1'b0;
      end else begin
         viol_o      <= (code != V_NONE);
         viol_code_o <= code;
         cfg_err_o   <= cfg_err_o | !cfg_ok;
      end
   end

   // R8: refresh or mode load with a busy bank is reported next cycle
   assert_allidle_R8: assert property (@(posedge clk) disable iff (rst)
      ((cmd == C_REF || cmd == C_LMR) && !all_idle) |=>
      (viol_o && viol_code_o == 3'd3));

   // R9: terminate on a non-reading bank is reported next cycle
   assert_bst_target_R9: assert property (@(posedge clk) disable iff (rst)
      (cmd == C_BST && eff[bank_i] != S_RDING) |=> (viol_code_o == 3'd4));

   // R12: the configuration error never drops without reset
   assert_cfg_sticky_R12: assert property (@(posedge clk) disable iff (rst)
      cfg_err_o |=> cfg_err_o);

endmodule

// File: tb/ddr_cmd_checker_tb_top.sv
module ddr_cmd_checker_tb_top;

   localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                          K_PRE = 3'd4, K_BST = 3'd5, K_REF = 3'd6, K_LMR = 3'd7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  cmd = K_NOP;
   logic [1:0]  bank = 2'd0;
   logic        ap = 1'b0;
   logic [1:0]  cl = 2'd3;
   logic [3:0]  bl = 4'd8;
   logic [3:0]  trp = 4'd2, trcd = 4'd2, twr = 4'd2, twtr = 4'd1;
   logic        viol;
   logic [2:0]  vcode;
   logic [11:0] bstate;
   logic        cfg_err;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit running = 1'b0;

   int         q_due[$];
   logic [2:0] q_code[$];
   string      q_tag[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ddr_cmd_checker dut_i (
      .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
      .cl_i(cl), .bl_i(bl), .trp_i(trp), .trcd_i(trcd), .twr_i(twr),
      .twtr_i(twtr), .viol_o(viol), .viol_code_o(vcode),
      .bank_state_o(bstate), .cfg_err_o(cfg_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: present one command for one capture edge, queue its verdict
   task automatic issue(input logic [2:0] c, input int b, input bit a,
                        input int exp, input string tag);
      cmd  = c;
      bank = 2'(b);
      ap   = a;
      q_due.push_back(cyc + 1);
      q_code.push_back(3'(exp));
      q_tag.push_back(tag);
      @(posedge clk);
      #2;
      cmd = K_NOP;
      ap  = 1'b0;
   endtask

   task automatic peek(input int b, input int exp, input string tag);
      chk(bstate[b*3 +: 3] == 3'(exp), {tag, " bank state"}, int'(bstate[b*3 +: 3]), exp);
   endtask

   // monitor: compare the registered verdict with the queued expectation
   always @(negedge clk) begin
      if (!rst && running) begin
         if (q_due.size() > 0 && q_due[0] == cyc) begin
            logic [2:0] e;
            string t;
            e = q_code.pop_front();
            t = q_tag.pop_front();
            void'(q_due.pop_front());
            chk(vcode == e && viol == (e != 3'd0), {t, " verdict"}, int'(vcode), int'(e));
         end else begin
            chk(vcode == 3'd0 && !viol, "R11 quiet cycle", int'(vcode), 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst = 1'b0;
      running = 1'b1;
      chk(bstate == 12'd0, "R13 reset states", int'(bstate), 0);
      chk(!viol && vcode == 3'd0, "R13 reset verdict", int'(vcode), 0);
      chk(!cfg_err, "R13 reset cfg", int'(cfg_err), 0);

      issue(K_REF, 0, 0, 0, "R8");
      issue(K_LMR, 0, 0, 0, "R8");

      issue(K_ACT, 0, 0, 0, "R1");  peek(0, 1, "R1");
      issue(K_RD,  0, 0, 1, "R1");
      issue(K_ACT, 1, 0, 0, "R1");  peek(0, 2, "R1");
      issue(K_RD,  0, 0, 0, "R3");  peek(0, 3, "R3");
      issue(K_WR,  1, 0, 5, "R10"); peek(1, 2, "R11");
      issue(K_BST, 1, 0, 4, "R9");
      issue(K_BST, 0, 0, 0, "R9");  peek(0, 2, "R9");
      issue(K_WR,  1, 0, 0, "R3");  peek(1, 4, "R3");
      issue(K_PRE, 0, 0, 0, "R2");  peek(0, 7, "R2");
      issue(K_ACT, 0, 0, 1, "R2");
      issue(K_ACT, 0, 0, 0, "R2");
      issue(K_NOP, 0, 0, 0, "R3");  peek(1, 2, "R3");
      issue(K_NOP, 0, 0, 0, "R11");

      issue(K_RD,  0, 1, 0, "R4");  peek(0, 5, "R4");
      issue(K_WR,  1, 0, 2, "R7");
      issue(K_RD,  1, 0, 2, "R7");
      issue(K_NOP, 0, 0, 0, "R7");
      issue(K_RD,  1, 0, 0, "R7");  peek(0, 7, "R4");
      issue(K_RD,  0, 0, 1, "R4");
      issue(K_ACT, 0, 0, 0, "R4");
      issue(K_NOP, 0, 0, 0, "R11");
      issue(K_NOP, 0, 0, 0, "R11");

      issue(K_WR,  1, 1, 0, "R5");  peek(1, 6, "R5");
      issue(K_WR,  0, 0, 2, "R6");
      issue(K_PRE, 1, 0, 1, "R5");
      issue(K_WR,  0, 0, 2, "R6");
      issue(K_ACT, 2, 0, 0, "R6");
      issue(K_RD,  0, 0, 2, "R6");
      issue(K_RD,  0, 0, 0, "R6");
      issue(K_NOP, 0, 0, 0, "R5");  peek(1, 7, "R5");
      issue(K_NOP, 0, 0, 0, "R5");  peek(1, 0, "R5");
      issue(K_REF, 0, 0, 3, "R8");

      bl = 4'd5;
      issue(K_NOP, 0, 0, 0, "R12");
      chk(cfg_err, "R12 cfg raise", int'(cfg_err), 1);
      bl = 4'd8;
      issue(K_NOP, 0, 0, 0, "R12");
      chk(cfg_err, "R12 cfg sticky", int'(cfg_err), 1);
      issue(K_NOP, 0, 0, 0, "R11");
      issue(K_NOP, 0, 0, 0, "R11");

      running = 1'b0;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      rst = 1'b0;
      chk(!cfg_err, "R13 cfg cleared", int'(cfg_err), 0);
      chk(bstate == 12'd0, "R13 states cleared", int'(bstate), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule